// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block sends one character at a time on an asynchronous serial line. The line rests high. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and a stop period of one, one and a half or two bit times. A parallel byte comes in over a valid/ready handshake. A single-cycle baud tick, running at sixteen times the bit rate, sets the pace of the frame.

Five line-control inputs shape the frame: a two-bit length code, parity on/off, parity sense, forced ("stick") parity and a long-stop select. The block captures them when it takes a byte and uses that copy until the frame ends. The data input is eight bits wide. When the length code asks for fewer bits, the upper bits of the byte are not sent. A busy flag covers the whole frame. The block takes the next byte on the cycle after the stop period ends.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1. Between frames the line stays at 1.
- R2: Length code `lc_wlen` values 2'b00, 2'b01, 2'b10 and 2'b11 send 5, 6, 7 and 8 data bits. Data goes out least significant bit first. Byte bits above the selected length are not sent.
- R3: The block accepts a byte on a clock edge where `in_valid` and `in_ready` are both 1. In the next cycle `txd` is 0 (start bit) and `busy` is 1. The start bit and each data, parity and full stop bit last 16 baud ticks. A tick that arrives in the same cycle as the accept does not shorten the start bit.
- R4: With `lc_par_en`=1 and `lc_stick`=0, a parity bit follows the last data bit and comes before the first stop bit. With `lc_even`=0 the data bits plus the parity bit hold an odd number of ones. With `lc_even`=1 they hold an even number.
- R5: With `lc_par_en`=1 and `lc_stick`=1, the parity bit equals the inverse of `lc_even`, whatever the data.
- R6: With `lc_par_en`=0 there is no parity slot, and `lc_even` and `lc_stick` have no effect on the line.
- R7: With `lc_two_stop`=0 the block sends one stop bit (16 ticks high). With `lc_two_stop`=1 it sends two stop bits (32 ticks) for 6-, 7- and 8-bit words, and one and a half stop bits (24 ticks) for 5-bit words.
- R8: The block captures the line-control inputs at accept. Changes to them during a frame do not change that frame.
- R9: `busy` is 1 from the start bit until the last stop tick, and `in_ready` is its inverse. While `busy` is 1, `in_valid` is ignored. After the last stop tick, `busy` is 0 and a byte can be accepted on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| lc_wlen | input | 2 | Data length code (00=5 ... 11=8 bits) |
| lc_par_en | input | 1 | Parity bit enable |
| lc_even | input | 1 | Parity sense: 1 even, 0 odd |
| lc_stick | input | 1 | Force parity bit to inverse of `lc_even` |
| lc_two_stop | input | 1 | Long stop period select |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
Two events can land on the same clock edge. The first is a baud tick together with the accept of a byte. The second is the final stop tick followed at once by the accept of the next byte. The bench drives a tick in the accept cycle for some frames. In every frame it still expects a full 16-tick start bit, and any shortening shows up as a level mismatch at a tick boundary. Every frame starts on the first cycle in which the previous one reports idle, so a lost cycle or a stuck busy flag shows up in the handshake checks.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even;
    logic       stick;
    logic       two_stop;
  } line_cfg_t;

  // index of the final data bit: 4..7 for length codes 0..3
  function automatic logic [2:0] last_data_idx(input logic [1:0] wlen);
    return 3'd4 + {1'b0, wlen};
  endfunction

  // keeps only the bits that belong to the selected word length
  function automatic logic [7:0] word_mask(input logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

  // parity slot value for a byte under a given line setting
  function automatic logic parity_value(input logic [7:0] data, input line_cfg_t cfg);
    logic [7:0] used;
    used = data & word_mask(cfg.wlen);
    if (cfg.stick) return ~cfg.even;
    return (^used) ^ ~cfg.even;
  endfunction

  // the second stop slot is half length only for 5-bit words
  function automatic logic short_second_stop(input line_cfg_t cfg);
    return cfg.wlen == 2'b00;
  endfunction

endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic baud_tick,
  input  logic half_slot,
  output logic bit_done
);
  localparam int CW       = $clog2(OVERSAMPLE);
  localparam int HALF_LEN = OVERSAMPLE / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last     = half_slot ? CW'(HALF_LEN - 1) : CW'(OVERSAMPLE - 1);
  assign bit_done = run && baud_tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (bit_done)   cnt <= '0;
    else if (baud_tick)  cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= last); // R3
  AST_CNT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0); // R3

endmodule

// File: rtl/sft_frame_fsm.sv
module sft_frame_fsm
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  line_cfg_t  cfg_in,
  input  logic [7:0] data_in,
  input  logic       bit_done,
  output logic       half_slot,
  output logic       busy,
  output logic       txd
);
  tx_state_e  state;
  line_cfg_t  cfg_q;
  logic [7:0] shreg;
  logic [2:0] idx;
  logic       par_q;
  logic       last_bit;

  assign last_bit  = (idx == last_data_idx(cfg_q.wlen));
  assign half_slot = (state == ST_STOP2) && short_second_stop(cfg_q);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START:  txd = 1'b0;
      ST_DATA:   txd = shreg[0];
      ST_PARITY: txd = par_q;
      default:   txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      shreg <= '0;
      idx   <= '0;
      par_q <= 1'b0;
    end else if (accept) begin
      state <= ST_START;
      cfg_q <= cfg_in;
      shreg <= data_in;
      idx   <= '0;
      par_q <= parity_value(data_in, cfg_in);
    end else if (bit_done) begin
      unique case (state)
        ST_START: state <= ST_DATA;
        ST_DATA: begin
          shreg <= shreg >> 1;
          idx   <= idx + 1'b1;
          if (last_bit) state <= cfg_q.par_en ? ST_PARITY : ST_STOP1;
        end
        ST_PARITY: state <= ST_STOP1;
        ST_STOP1:  state <= cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
        ST_STOP2:  state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  AST_START_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == ST_START) && !txd); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(cfg_q)); // R8
  AST_PARITY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARITY) |-> cfg_q.par_en); // R6
  AST_SECOND_STOP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP2) |-> cfg_q.two_stop); // R7
  AST_DATA_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> idx <= last_data_idx(cfg_q.wlen)); // R2

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] lc_wlen,
  input  logic       lc_par_en,
  input  logic       lc_even,
  input  logic       lc_stick,
  input  logic       lc_two_stop,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       txd,
  output logic       busy
);
  line_cfg_t cfg_now;
  logic      accept;
  logic      bit_done;
  logic      half_slot;

  assign cfg_now  = '{wlen: lc_wlen, par_en: lc_par_en, even: lc_even,
                      stick: lc_stick, two_stop: lc_two_stop};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  sft_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .baud_tick (baud_tick),
    .half_slot (half_slot),
    .bit_done  (bit_done)
  );

  sft_frame_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cfg_in    (cfg_now),
    .data_in   (in_data),
    .bit_done  (bit_done),
    .half_slot (half_slot),
    .busy      (busy),
    .txd       (txd)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1
  AST_BUSY_RISE_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid)); // R9
  AST_FRAME_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick)); // R9

endmodule

// File: tb/serial_frame_tx_test.sv
`timescale 1ns/1ps
module serial_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] lc_wlen = 2'b00;
  logic       lc_par_en = 1'b0, lc_even = 1'b0, lc_stick = 1'b0, lc_two_stop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, txd, busy;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic lvl [16];
  int   tks [16];
  int   nslots;

  always #2.5 clk = ~clk;

  serial_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .lc_wlen(lc_wlen), .lc_par_en(lc_par_en), .lc_even(lc_even),
    .lc_stick(lc_stick), .lc_two_stop(lc_two_stop),
    .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .txd(txd), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  // bench-side parity: count the ones explicitly
  function automatic logic exp_parity(input logic [7:0] d, input int nb,
                                      input logic ev, input logic st);
    int ones = 0;
    if (st) return !ev;
    for (int i = 0; i < nb; i++) ones += d[i];
    // odd total wanted when ev=0, even total when ev=1
    return ev ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  task automatic build(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                       input logic ev, input logic st, input logic ts);
    int nb = 5 + int'(wl);
    nslots = 0;
    lvl[nslots] = 1'b0; tks[nslots] = 16; nslots++;              // R3 start
    for (int i = 0; i < nb; i++) begin                          // R2 lsb first
      lvl[nslots] = d[i]; tks[nslots] = 16; nslots++;
    end
    if (pe) begin                                               // R4 R5 R6
      lvl[nslots] = exp_parity(d, nb, ev, st); tks[nslots] = 16; nslots++;
    end
    lvl[nslots] = 1'b1; tks[nslots] = 16; nslots++;              // R7
    if (ts) begin
      lvl[nslots] = 1'b1; tks[nslots] = (nb == 5) ? 8 : 16; nslots++;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                      input logic ev, input logic st, input logic ts,
                      input bit tick_at_accept, input bit disturb);
    build(d, wl, pe, ev, st, ts);
    chk("R9 ready before accept", in_ready, 1'b1);
    in_data = d; lc_wlen = wl; lc_par_en = pe; lc_even = ev;
    lc_stick = st; lc_two_stop = ts; in_valid = 1'b1;
    baud_tick = tick_at_accept;
    @(negedge clk);
    baud_tick = 1'b0;
    in_valid = disturb;
    chk("R3 busy after accept", busy, 1'b1);
    chk("R9 ready low while busy", in_ready, 1'b0);
    for (int s = 0; s < nslots; s++) begin
      for (int k = 0; k < tks[s]; k++) begin
        int gap = $urandom % 3;
        repeat (gap) begin
          chk("R2-R7 line level", txd, lvl[s]);
          @(negedge clk);
        end
        chk("R2-R7 line level", txd, lvl[s]);
        chk("R9 busy during frame", busy, 1'b1);
        if (disturb) begin                                     // R8 R9
          in_data = 8'($urandom);
          {lc_wlen, lc_par_en, lc_even, lc_stick, lc_two_stop} = 6'($urandom);
          if (s == nslots - 1 && k == tks[s] - 1) in_valid = 1'b0;
        end
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
      end
    end
    chk("R9 idle after last stop", busy, 1'b0);
    chk("R1 line high between frames", txd, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1 reset line", txd, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1'b1);
    // R2: each length code, high bits must not appear
    for (int w = 0; w < 4; w++) send(8'hE5, 2'(w), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: odd and even parity over several patterns
    send(8'h00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h37, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'hA9, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: stick parity both senses
    send(8'hFF, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(8'hFE, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: parity disabled with sense and stick set
    send(8'h5A, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: one and a half versus two stop bits
    send(8'h13, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    send(8'h13, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R3: tick in the accept cycle; R8: inputs churn during frame
    send(8'hC3, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'h81, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int n = 0; n < 40; n++) begin
      logic [5:0] c = 6'($urandom);
      send(8'($urandom), c[5:4], c[3], c[2], c[1], c[0],
           1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule